// File: doc/BRIEF.md
# Paired Compare Waveform Generator

This block makes two waveform pins from one 16-bit timer count. Each channel holds its own compare register. The register is loaded either directly or through a buffer stage. Each pin changes level when the incoming count equals its compare value. How it changes depends on the channel's mode:

- **Toggle mode:** the pin flips on a match.
- **Pair mode:** available on channel 1 only. The pin flips when the count equals either of the two compare values.
- **Up/down mode:** a match drives the pin to the active level while counting up and to the inactive level while counting down. The active level is selected by a polarity input. Two compare values are reserved: 0x0000 holds the pin active and 0xFFFF holds it inactive.

Each channel also has a sticky match flag.

The timer count arrives as a stream with a valid strobe: `cnt_vld_i` marks a cycle in which `cnt_i`, `cnt_dn_i` and `at_peak_i` describe a fresh count. There is no ready signal. The block accepts every count the timer presents, so the timer is never back-pressured. Compare writes and flag writes are plain single-cycle strobes. The pin outputs and flags are registered and change on the clock edge that samples the event.

Top module: `cmp_wave_pair`

## Requirements
- R1: After reset both pins are low, both flags are clear, and both compare registers and buffers hold 0.
- R2: In toggle mode (mode code 00, and code 01 on channel 0), an enabled channel inverts its pin when a valid count equals its compare value, whichever way the count is moving, and sets its flag (bit 0 for channel 0, bit 1 for channel 1).
- R3: In toggle and pair modes, a compare value above `peak_i` never inverts the pin and never sets the flag, even if the count equals it.
- R4: In pair mode (mode code 01, channel 1 only), pin 1 inverts when the count equals either compare value, and only once when both are equal. Channel 0 keeps its own toggle behaviour. Flag 1 is set only by a match on compare value 1.
- R5: A channel whose enable is low holds its pin and sets no flag. Pair mode on channel 1 additionally needs channel 0's enable high.
- R6: In up/down mode (mode code 10), a match moves the pin to the active level while counting up (`cnt_dn_i`=0) and to the inactive level while counting down. The active level is high when `pol_low_i`=0 and low when it is 1.
- R7: In up/down mode, a compare value of 0x0000 drives the pin to the active level in every enabled cycle, and 0xFFFF drives it to the inactive level, with or without a valid count.
- R8: In up/down mode, a match in a cycle with `at_peak_i` high leaves the pin unchanged and does not set the flag.
- R9: With `buf_en_i`=0, a compare write loads the compare register at the clock edge. A match is judged against the new value from the next cycle on.
- R10: With `buf_en_i`=1, a write only fills the buffer. The buffer moves into the compare register on a valid count equal to 0x0000 (`xfer_peak_i`=0) or on a valid count with `at_peak_i` high (`xfer_peak_i`=1). The compare in that same cycle already uses the transferred value.
- R11: Flags are sticky. A flag write clears each bit whose data bit is 0 and leaves bits written with 1 unchanged. A match in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_vld_i | input | 1 | Count stream valid |
| cnt_i | input | 16 | Timer count value |
| cnt_dn_i | input | 1 | 1 when the timer is counting down |
| at_peak_i | input | 1 | Count equals the peak value |
| peak_i | input | 16 | Timer peak value |
| en0_i | input | 1 | Channel 0 enable |
| en1_i | input | 1 | Channel 1 enable |
| mode0_i | input | 2 | Channel 0 mode (00 toggle, 10 up/down) |
| mode1_i | input | 2 | Channel 1 mode (00 toggle, 01 pair, 10 up/down) |
| pol_low_i | input | 1 | Active level low in up/down mode |
| buf_en_i | input | 1 | Compare buffer enable |
| xfer_peak_i | input | 1 | Buffer transfer at peak (1) or at zero (0) |
| wr_en_i | input | 1 | Compare write strobe |
| wr_sel_i | input | 1 | Compare register select |
| wr_data_i | input | 16 | Compare write data |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 2 | Flag write data, 0 clears a bit |
| rt0_o | output | 1 | Waveform pin 0 |
| rt1_o | output | 1 | Waveform pin 1 |
| flag_o | output | 2 | Sticky match flags |

## Verification
Two pairs of functions can land in the same clock cycle.

- **Buffer transfer and compare:** a buffered value reaches the compare register on the very count that it matches. The bench provokes this by loading a buffer with the peak value and then presenting the peak count. The pin must flip in that cycle rather than one period later.
- **Flag set and flag clear:** a software clear of a flag can coincide with a fresh match on the same flag. The bench issues a clear-all write together with a matching count. It then checks that the matched flag remains set and that the other flag is cleared.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  typedef enum logic [1:0] {
    CM_TOGGLE = 2'b00,
    CM_PAIR   = 2'b01,
    CM_UPDN   = 2'b10,
    CM_RSVD   = 2'b11
  } cmp_mode_e;

  localparam int NCH = 2;
endpackage

// File: rtl/cwp_cmp_reg.sv
module cwp_cmp_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         buf_en_i,
  input  logic         xfer_i,
  output logic [W-1:0] eff_o,
  output logic [W-1:0] act_o
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [W-1:0] buf_q;
  logic [W-1:0] act_q;
  logic         take_buf;

  // a transfer makes the buffered value live in the same cycle
  assign take_buf = buf_en_i && xfer_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_i) begin
        buf_q <= wdata_i;
      end
      if (!buf_en_i && wr_i) begin
        act_q <= wdata_i;
      end else if (take_buf) begin
        act_q <= buf_q;
      end
    end
  end

  assign eff_o = take_buf ? buf_q : act_q;
  assign act_o = act_q;
endmodule

// File: rtl/cwp_chan.sv
module cwp_chan
  import cwp_pkg::*;
#(
  parameter int W       = 16,
  parameter bit PAIR_OK = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         peer_en_i,
  input  cmp_mode_e    mode_i,
  input  logic         pol_low_i,
  input  logic [W-1:0] cmp_i,
  input  logic         cnt_vld_i,
  input  logic [W-1:0] cnt_i,
  input  logic         cnt_dn_i,
  input  logic         at_peak_i,
  input  logic [W-1:0] peak_i,
  input  logic         alt_hit_i,
  output logic         rt_o,
  output logic         flag_set_o,
  output logic         tog_hit_o
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [W-1:0] ALL_ONES = '1;
  localparam logic [W-1:0] ALL_ZERO = '0;

  logic is_pair;
  logic is_updn;
  logic run;
  logic eq;
  logic in_rng;
  logic tog_hit;
  logic updn_hit;
  logic act_lvl;
  logic rt_q;
  logic rt_d;

  assign is_pair  = PAIR_OK && (mode_i == CM_PAIR);
  assign is_updn  = (mode_i == CM_UPDN);
  assign run      = en_i && (!is_pair || peer_en_i);
  assign eq       = cnt_vld_i && (cnt_i == cmp_i);
  assign in_rng   = (cmp_i <= peak_i);
  assign tog_hit  = eq && in_rng;
  assign updn_hit = eq && !at_peak_i && (cmp_i != ALL_ZERO) && (cmp_i != ALL_ONES);
  assign act_lvl  = !pol_low_i;

  always_comb begin
    rt_d = rt_q;
    if (run) begin
      if (is_updn) begin
        if (cmp_i == ALL_ZERO) begin
          rt_d = act_lvl;
        end else if (cmp_i == ALL_ONES) begin
          rt_d = !act_lvl;
        end else if (updn_hit) begin
          rt_d = cnt_dn_i ? !act_lvl : act_lvl;
        end
      end else if (is_pair) begin
        if (tog_hit || alt_hit_i) begin
          rt_d = !rt_q;
        end
      end else if (tog_hit) begin
        rt_d = !rt_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rt_q <= 1'b0;
    end else begin
      rt_q <= rt_d;
    end
  end

  assign rt_o       = rt_q;
  assign flag_set_o = run && (is_updn ? updn_hit : tog_hit);
  assign tog_hit_o  = tog_hit;
endmodule

// File: rtl/cmp_wave_pair.sv
module cmp_wave_pair
  import cwp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_vld_i,
  input  logic [W-1:0] cnt_i,
  input  logic         cnt_dn_i,
  input  logic         at_peak_i,
  input  logic [W-1:0] peak_i,
  input  logic         en0_i,
  input  logic         en1_i,
  input  logic [1:0]   mode0_i,
  input  logic [1:0]   mode1_i,
  input  logic         pol_low_i,
  input  logic         buf_en_i,
  input  logic         xfer_peak_i,
  input  logic         wr_en_i,
  input  logic         wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         flag_wr_i,
  input  logic [1:0]   flag_wdata_i,
  output logic         rt0_o,
  output logic         rt1_o,
  output logic [1:0]   flag_o
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [W-1:0] ZERO_CNT = '0;

  logic                    xfer_now;
  logic [NCH-1:0]          en_v;
  logic [NCH-1:0]          peer_v;
  logic [NCH-1:0][1:0]     mode_v;
  logic [NCH-1:0][W-1:0]   eff_v;
  logic [NCH-1:0][W-1:0]   act_v;
  logic [NCH-1:0]          rt_v;
  logic [NCH-1:0]          set_v;
  logic [NCH-1:0]          tog_v;
  logic [NCH-1:0]          alt_v;
  logic [NCH-1:0]          clr_v;
  logic [NCH-1:0]          flag_q;
  logic [W-1:0]            eff0;
  logic [W-1:0]            eff1;

  assign xfer_now = cnt_vld_i && (xfer_peak_i ? at_peak_i : (cnt_i == ZERO_CNT));

  assign en_v   = {en1_i, en0_i};
  assign peer_v = {en0_i, en1_i};
  assign mode_v = {mode1_i, mode0_i};
  assign alt_v  = {tog_v[0], 1'b0};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cwp_cmp_reg #(.W(W)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_en_i && (wr_sel_i == g[0])),
      .wdata_i (wr_data_i),
      .buf_en_i(buf_en_i),
      .xfer_i  (xfer_now),
      .eff_o   (eff_v[g]),
      .act_o   (act_v[g])
    );

    cwp_chan #(.W(W), .PAIR_OK(g == 1)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_v[g]),
      .peer_en_i (peer_v[g]),
      .mode_i    (cmp_mode_e'(mode_v[g])),
      .pol_low_i (pol_low_i),
      .cmp_i     (eff_v[g]),
      .cnt_vld_i (cnt_vld_i),
      .cnt_i     (cnt_i),
      .cnt_dn_i  (cnt_dn_i),
      .at_peak_i (at_peak_i),
      .peak_i    (peak_i),
      .alt_hit_i (alt_v[g]),
      .rt_o      (rt_v[g]),
      .flag_set_o(set_v[g]),
      .tog_hit_o (tog_v[g])
    );

    assign clr_v[g] = flag_wr_i && !flag_wdata_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q[g] <= 1'b0;
      end else begin
        flag_q[g] <= (flag_q[g] && !clr_v[g]) || set_v[g];
      end
    end
  end

  assign eff0   = eff_v[0];
  assign eff1   = eff_v[1];
  assign rt0_o  = rt_v[0];
  assign rt1_o  = rt_v[1];
  assign flag_o = flag_q;
endmodule

// File: rtl/cwp_chk.sv
module cwp_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en0_i,
  input logic         en1_i,
  input logic [1:0]   mode0_i,
  input logic         pol_low_i,
  input logic         at_peak_i,
  input logic [W-1:0] peak_i,
  input logic [W-1:0] eff0,
  input logic         flag_wr_i,
  input logic [1:0]   flag_wdata_i,
  input logic         rt0_o,
  input logic         rt1_o,
  input logic [1:0]   flag_o
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [W-1:0] ONES = '1;

  // R11
  flag0_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o[0] && !(flag_wr_i && !flag_wdata_i[0])) |=> flag_o[0]);

  // R11
  flag1_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o[1] && !(flag_wr_i && !flag_wdata_i[1])) |=> flag_o[1]);

  // R5
  ch0_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en0_i |=> $stable(rt0_o));

  // R5
  ch1_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en1_i |=> $stable(rt1_o));

  // R7
  updn_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en0_i && mode0_i == 2'b10 && eff0 == '0) |=> (rt0_o == !$past(pol_low_i)));

  // R8
  updn_peak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en0_i && mode0_i == 2'b10 && at_peak_i && eff0 != '0 && eff0 != ONES)
      |=> $stable(rt0_o));

  // R3
  over_peak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en0_i && mode0_i != 2'b10 && eff0 > peak_i) |=> $stable(rt0_o));
endmodule

bind cmp_wave_pair cwp_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en0_i       (en0_i),
  .en1_i       (en1_i),
  .mode0_i     (mode0_i),
  .pol_low_i   (pol_low_i),
  .at_peak_i   (at_peak_i),
  .peak_i      (peak_i),
  .eff0        (eff0),
  .flag_wr_i   (flag_wr_i),
  .flag_wdata_i(flag_wdata_i),
  .rt0_o       (rt0_o),
  .rt1_o       (rt1_o),
  .flag_o      (flag_o)
);

// File: tb/cmp_wave_pair_tb.sv
module cmp_wave_pair_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_vld;
  logic [15:0] cnt;
  logic        cnt_dn;
  logic        at_peak;
  logic [15:0] peak;
  logic        en0, en1;
  logic [1:0]  mode0, mode1;
  logic        pol_low;
  logic        buf_en;
  logic        xfer_peak;
  logic        wr_en;
  logic        wr_sel;
  logic [15:0] wr_data;
  logic        flag_wr;
  logic [1:0]  flag_wdata;
  logic        rt0, rt1;
  logic [1:0]  flag;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cmp_wave_pair dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cnt_vld_i(cnt_vld), .cnt_i(cnt),
    .cnt_dn_i(cnt_dn), .at_peak_i(at_peak), .peak_i(peak),
    .en0_i(en0), .en1_i(en1), .mode0_i(mode0), .mode1_i(mode1),
    .pol_low_i(pol_low), .buf_en_i(buf_en), .xfer_peak_i(xfer_peak),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .flag_wr_i(flag_wr), .flag_wdata_i(flag_wdata),
    .rt0_o(rt0), .rt1_o(rt1), .flag_o(flag)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cnt_vld = 0; cnt = 0; cnt_dn = 0; at_peak = 0; peak = 16'd100;
    en0 = 1; en1 = 1; mode0 = 2'b00; mode1 = 2'b00; pol_low = 0; buf_en = 0;
    xfer_peak = 0; wr_en = 0; wr_sel = 0; wr_data = 0; flag_wr = 0; flag_wdata = 0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic wr_cmp(input logic sel, input logic [15:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic step(input logic [15:0] c, input logic dn, input logic pk);
    cnt_vld = 1; cnt = c; cnt_dn = dn; at_peak = pk;
    tick();
    cnt_vld = 0; at_peak = 0;
  endtask

  task automatic flag_write(input logic [1:0] d);
    flag_wr = 1; flag_wdata = d;
    tick();
    flag_wr = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rt0", rt0, 0);
    chk("R1 rt1", rt1, 0);
    chk("R1 flag", flag, 0);
  endtask

  task automatic t_toggle();
    do_reset();
    wr_cmp(0, 16'd5); wr_cmp(1, 16'd9);
    step(16'd5, 0, 0);
    chk("R2 rt0 up match", rt0, 1);
    chk("R2 rt1 idle", rt1, 0);
    chk("R2 flag0", flag, 2'b01);
    step(16'd9, 1, 0);
    chk("R2 rt1 down match", rt1, 1);
    chk("R2 flag both", flag, 2'b11);
    step(16'd6, 0, 0);
    chk("R2 no match", rt0, 1);
    step(16'd5, 1, 0);
    chk("R2 rt0 back", rt0, 0);
    // R9: write and matching count in same cycle, old value still compared
    wr_en = 1; wr_sel = 0; wr_data = 16'd12; cnt_vld = 1; cnt = 16'd12;
    tick();
    wr_en = 0; cnt_vld = 0;
    chk("R9 same cycle uses old", rt0, 0);
    step(16'd12, 0, 0);
    chk("R9 next cycle uses new", rt0, 1);
  endtask

  task automatic t_range();
    do_reset();
    wr_cmp(0, 16'd150);
    step(16'd150, 0, 0);
    chk("R3 above peak rt0", rt0, 0);
    chk("R3 above peak flag", flag, 0);
    wr_cmp(0, 16'd100);
    step(16'd100, 0, 1);
    chk("R3 equal peak toggles", rt0, 1);
  endtask

  task automatic t_pair();
    do_reset();
    mode1 = 2'b01;
    wr_cmp(0, 16'd10); wr_cmp(1, 16'd20);
    step(16'd10, 0, 0);
    chk("R4 rt0 own", rt0, 1);
    chk("R4 rt1 via cmp0", rt1, 1);
    chk("R4 flag only 0", flag, 2'b01);
    step(16'd20, 0, 0);
    chk("R4 rt1 via cmp1", rt1, 0);
    chk("R4 rt0 hold", rt0, 1);
    chk("R4 flag1", flag, 2'b11);
    wr_cmp(1, 16'd10);
    step(16'd10, 0, 0);
    chk("R4 both equal single flip", rt1, 1);
    chk("R4 rt0 flip", rt0, 0);
    flag_write(2'b00);
    en0 = 0;
    step(16'd10, 0, 0);
    chk("R5 pair needs en0 rt1", rt1, 1);
    chk("R5 disabled rt0", rt0, 0);
    chk("R5 no flags", flag, 0);
  endtask

  task automatic t_updn();
    do_reset();
    en1 = 0; mode0 = 2'b10; peak = 16'd80;
    wr_cmp(0, 16'd40);
    step(16'd40, 0, 0);
    chk("R6 up active high", rt0, 1);
    chk("R6 flag", flag, 2'b01);
    step(16'd40, 0, 0);
    chk("R6 up stays active", rt0, 1);
    step(16'd40, 1, 0);
    chk("R6 down inactive", rt0, 0);
    pol_low = 1;
    step(16'd40, 1, 0);
    chk("R6 low pol down high", rt0, 1);
    step(16'd40, 0, 0);
    chk("R6 low pol up low", rt0, 0);
    pol_low = 0;
    wr_cmp(0, 16'd80);
    step(16'd80, 0, 0);
    chk("R8 setup", rt0, 1);
    flag_write(2'b00);
    step(16'd80, 1, 1);
    chk("R8 peak no change", rt0, 1);
    chk("R8 peak no flag", flag, 0);
  endtask

  task automatic t_special();
    do_reset();
    en1 = 0; mode0 = 2'b10;
    wr_cmp(0, 16'hFFFF);
    tick();
    chk("R7 ffff inactive", rt0, 0);
    wr_cmp(0, 16'h0000);
    tick();
    chk("R7 zero active", rt0, 1);
    wr_cmp(0, 16'hFFFF);
    pol_low = 1;
    tick();
    chk("R7 ffff inactive low pol", rt0, 1);
    wr_cmp(0, 16'h0000);
    tick();
    chk("R7 zero active low pol", rt0, 0);
  endtask

  task automatic t_buffer();
    do_reset();
    en1 = 0; buf_en = 1; xfer_peak = 0;
    wr_cmp(0, 16'd7);
    step(16'd7, 0, 0);
    chk("R10 buffered not live", rt0, 0);
    step(16'd0, 0, 0);
    chk("R10 zero transfer", rt0, 0);
    step(16'd7, 0, 0);
    chk("R10 live after zero", rt0, 1);
    xfer_peak = 1; peak = 16'd50;
    wr_cmp(0, 16'd50);
    step(16'd0, 0, 0);
    chk("R10 no zero xfer in peak sel", rt0, 1);
    step(16'd50, 0, 1);
    chk("R10 peak transfer same cycle", rt0, 0);
  endtask

  task automatic t_flags();
    do_reset();
    wr_cmp(0, 16'd5); wr_cmp(1, 16'd6);
    step(16'd5, 0, 0); step(16'd6, 0, 0);
    chk("R11 both set", flag, 2'b11);
    flag_write(2'b10);
    chk("R11 clear bit0 only", flag, 2'b10);
    tick();
    chk("R11 sticky", flag, 2'b10);
    flag_wr = 1; flag_wdata = 2'b00; cnt_vld = 1; cnt = 16'd6;
    tick();
    flag_wr = 0; cnt_vld = 0;
    chk("R11 set beats clear", flag, 2'b10);
    flag_write(2'b00);
    chk("R11 cleared", flag, 2'b00);
  endtask

  initial begin
    t_reset();
    t_toggle();
    t_range();
    t_pair();
    t_updn();
    t_special();
    t_buffer();
    t_flags();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule